// File: doc/BRIEF.md
# Heat-Bath Ising Lattice Sweeper

This block runs heat-bath Monte Carlo sweeps over a three-dimensional Ising spin-glass lattice with periodic boundaries. The spins and the nearest-neighbour couplings are all held in registers inside the block. A fixed bank of parallel update engines handles the lattice one plane at a time. Within a plane it first updates every site of one checkerboard colour and then every site of the other. Each engine sums the agreement of its six neighbours with their couplings. It uses that count to pick one of seven 32-bit thresholds and sets the spin to +1 when a fresh word from its own lagged-Fibonacci generator falls below that threshold. The spin's previous value plays no part in this.

A host loads the couplings, the initial spins, the seven thresholds (which encode the temperature) and the generator seeds while the block is idle. It then pulses `start` and waits for `done`. After that it reads the lattice back one row at a time. The default configuration is a 16-edge lattice with 32 engines. This gives 8 cycles per plane. The same structure scales to a 32-edge lattice with 128 engines.

Top module: `hb_lattice_engine`

## Requirements
- R1: After reset, `busy` and `done` are low and every row read back is all zeros (bit value 0 means spin −1, 1 means +1).
- R2: A `start` pulse sampled while idle raises `busy` and clears `done` at that clock edge. A `start` sampled while `busy` is high has no effect on the sweep or its length.
- R3: `done` rises, and `busy` falls, exactly L·2·(L²/2/ENG) clock edges after the edge that accepted `start`. This is 128 edges with the defaults (16 planes of 8 cycles). `done` stays high until the next accepted `start`.
- R4: Each updated site takes the value 1 when its random word is unsigned-less-than threshold entry n and takes 0 otherwise. Here n (0..6) counts the six neighbours whose coupling bit equals that neighbour's spin bit, so the local field is 2n−6. The site's old value is not used.
- R5: Every engine owns a generator with a history of 61 words. Each busy cycle it produces r = (r[n−24] + r[n−55] mod 2³²) XOR r[n−61] and consumes that word. A seed write shifts `seed_data` in as the newest history word of engine `seed_eng`, so the 61st write becomes r[n−1]. Seed writes made while busy are ignored.
- R6: Planes are processed in order z = 0..L−1. In each plane, colour 0 (sites with (x+y+z) even) takes L²/2/ENG cycles, and colour 1 then takes the same number. In cycle k of a colour, engine e updates site g = k·ENG+e, with y = g div (L/2) and x = 2·(g mod L/2) + ((y+z+colour) mod 2). Neighbours wrap at the lattice edges.
- R7: A sweep with all thresholds zero leaves every spin 0. A sweep with all thresholds 0xFFFFFFFF leaves every spin 1, except where the random word itself is 0xFFFFFFFF.
- R8: A lattice write stores `lat_data` into row (`lat_plane`, `lat_row`), with bit x holding site x. `lat_sel` selects the target: 0 spins, 1 +x couplings, 2 +y couplings, 3 +z couplings. A coupling bit at (x,y,z) joins that site to its +axis neighbour, and bit 1 means J = +1. Lattice writes and threshold writes made while busy are ignored.
- R9: `rd_data` shows the spins of row (`rd_plane`, `rd_row`) combinationally, in the same cycle the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one sweep when idle |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Last sweep finished |
| tbl_we | input | 1 | Threshold write enable |
| tbl_idx | input | 3 | Threshold entry 0..6 (field 2·idx−6) |
| tbl_data | input | 32 | Threshold value |
| seed_we | input | 1 | Seed shift enable |
| seed_eng | input | $clog2(ENG) | Engine receiving the seed word |
| seed_data | input | 32 | Seed word |
| lat_we | input | 1 | Lattice row write enable |
| lat_sel | input | 2 | 0 spins, 1 +x, 2 +y, 3 +z couplings |
| lat_plane | input | $clog2(L) | Plane (z) of the row written |
| lat_row | input | $clog2(L) | Row (y) of the row written |
| lat_data | input | L | Row contents, bit x = site x |
| rd_plane | input | $clog2(L) | Plane of the row read |
| rd_row | input | $clog2(L) | Row of the row read |
| rd_data | output | L | Spins of the addressed row |

## Verification
`busy` is due one edge after the accepting `start`, and `done` is due exactly 128 edges after it. The bench therefore steps edge by edge from the start and checks `done` low at edge 127 and high at edge 128. Spin results are compared only after `done`, and at that point the bench's arithmetic model has replayed every engine's draws in R6 order. Readback is combinational, so rows are checked one time step after the address changes and away from any clock edge. Stimuli that must be ignored are injected a few edges into a sweep, and their absence is shown by the sweep's timing and by the lattice and later sweeps matching the model.

// File: rtl/hb_lattice_engine.sv
module hb_lattice_engine #(
  parameter int L     = 16,
  parameter int ENG   = 32,
  parameter int LAG_A = 24,
  parameter int LAG_B = 55,
  parameter int LAG_C = 61
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  input  logic                   tbl_we,
  input  logic [2:0]             tbl_idx,
  input  logic [31:0]            tbl_data,
  input  logic                   seed_we,
  input  logic [$clog2(ENG)-1:0] seed_eng,
  input  logic [31:0]            seed_data,
  input  logic                   lat_we,
  input  logic [1:0]             lat_sel,
  input  logic [$clog2(L)-1:0]   lat_plane,
  input  logic [$clog2(L)-1:0]   lat_row,
  input  logic [L-1:0]           lat_data,
  input  logic [$clog2(L)-1:0]   rd_plane,
  input  logic [$clog2(L)-1:0]   rd_row,
  output logic [L-1:0]           rd_data
);
  localparam int LW  = $clog2(L);
  localparam int EW  = $clog2(ENG);
  localparam int HR  = L / 2;
  localparam int CPC = (L * L / 2) / ENG;
  localparam int KW  = (CPC > 1) ? $clog2(CPC) : 1;

  logic [L-1:0]  spin [L][L];
  logic [L-1:0]  jx   [L][L];
  logic [L-1:0]  jy   [L][L];
  logic [L-1:0]  jz   [L][L];
  logic [31:0]   thr  [8];

  logic          busy_q, done_q, col;
  logic [LW-1:0] zc;
  logic [KW-1:0] kc;
  logic          last;

  logic [ENG*LW-1:0] ex_f, ey_f;
  logic [ENG-1:0]    up;

  assign busy    = busy_q;
  assign done    = done_q;
  assign rd_data = spin[rd_plane][rd_row];
  assign last    = busy_q && (zc == LW'(L - 1)) && col && (kc == KW'(CPC - 1));

  for (genvar e = 0; e < ENG; e++) begin : g_eng
    logic [31:0]   hist [LAG_C];
    logic [31:0]   rnd;
    logic          seed_hit;
    int            gi, yi, xi;
    logic [LW-1:0] x_, y_, xp, xm, yp, ym, zp, zm;
    logic [5:0]    agree;
    logic [2:0]    cnt;

    assign rnd      = (hist[LAG_A-1] + hist[LAG_B-1]) ^ hist[LAG_C-1];
    assign seed_hit = seed_we && !busy_q && (seed_eng == EW'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < LAG_C; i++) hist[i] <= '0;
      end else if (busy_q || seed_hit) begin
        for (int i = LAG_C - 1; i > 0; i--) hist[i] <= hist[i-1];
        hist[0] <= busy_q ? rnd : seed_data;
      end
    end

    always_comb begin
      gi = ENG * int'(kc) + e;
      yi = gi / HR;
      xi = 2 * (gi % HR) + ((yi + int'(zc) + int'(col)) % 2);
      x_ = LW'(xi);
      y_ = LW'(yi);
      xp = x_ + 1'b1;
      xm = x_ - 1'b1;
      yp = y_ + 1'b1;
      ym = y_ - 1'b1;
      zp = zc + 1'b1;
      zm = zc - 1'b1;
      agree[0] = jx[zc][y_][x_]  ~^ spin[zc][y_][xp];
      agree[1] = jx[zc][y_][xm]  ~^ spin[zc][y_][xm];
      agree[2] = jy[zc][y_][x_]  ~^ spin[zc][yp][x_];
      agree[3] = jy[zc][ym][x_]  ~^ spin[zc][ym][x_];
      agree[4] = jz[zc][y_][x_]  ~^ spin[zp][y_][x_];
      agree[5] = jz[zm][y_][x_]  ~^ spin[zm][y_][x_];
      cnt = 3'($countones(agree));
    end

    assign ex_f[e*LW +: LW] = x_;
    assign ey_f[e*LW +: LW] = y_;
    assign up[e]            = rnd < thr[cnt];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int z = 0; z < L; z++)
        for (int y = 0; y < L; y++) begin
          spin[z][y] <= '0;
          jx[z][y]   <= '0;
          jy[z][y]   <= '0;
          jz[z][y]   <= '0;
        end
    end else if (busy_q) begin
      for (int e = 0; e < ENG; e++)
        spin[zc][ey_f[e*LW +: LW]][ex_f[e*LW +: LW]] <= up[e];
    end else if (lat_we) begin
      case (lat_sel)
        2'd0: spin[lat_plane][lat_row] <= lat_data;
        2'd1: jx[lat_plane][lat_row]   <= lat_data;
        2'd2: jy[lat_plane][lat_row]   <= lat_data;
        default: jz[lat_plane][lat_row] <= lat_data;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) thr[i] <= '0;
    end else if (tbl_we && !busy_q && tbl_idx != 3'd7) begin
      thr[tbl_idx] <= tbl_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      zc     <= '0;
      col    <= 1'b0;
      kc     <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        zc     <= '0;
        col    <= 1'b0;
        kc     <= '0;
      end
    end else begin
      if (kc == KW'(CPC - 1)) begin
        kc  <= '0;
        col <= ~col;
        if (col) zc <= zc + 1'b1;
      end else begin
        kc <= kc + 1'b1;
      end
      if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hb_lattice_engine_chk.sv
module hb_lattice_engine_chk #(
  parameter int L   = 16,
  parameter int ENG = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 lat_we,
  input logic [$clog2(L)-1:0] rd_plane,
  input logic [$clog2(L)-1:0] rd_row,
  input logic [L-1:0]         rd_data
);
  localparam int TOTAL = L * 2 * ((L * L / 2) / ENG);

  int run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_cnt <= 0;
    else if (start && !busy) run_cnt <= 0;
    else if (busy)           run_cnt <= run_cnt + 1;
  end

  a_r2_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  a_r2_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r3_sweep_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && run_cnt == TOTAL));

  a_r9_idle_readback_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!busy && !lat_we) && $stable(rd_plane) && $stable(rd_row)) |-> $stable(rd_data));
endmodule

bind hb_lattice_engine hb_lattice_engine_chk #(.L(L), .ENG(ENG)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .lat_we(lat_we), .rd_plane(rd_plane), .rd_row(rd_row), .rd_data(rd_data)
);

// File: tb/hb_lattice_engine_bench.sv
module hb_lattice_engine_bench;
  localparam int L     = 16;
  localparam int ENG   = 32;
  localparam int LW    = $clog2(L);
  localparam int EW    = $clog2(ENG);
  localparam int CPC   = (L * L / 2) / ENG;
  localparam int TOTAL = L * 2 * CPC;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic busy, done;
  logic tbl_we = 0;
  logic [2:0] tbl_idx = 0;
  logic [31:0] tbl_data = 0;
  logic seed_we = 0;
  logic [EW-1:0] seed_eng = 0;
  logic [31:0] seed_data = 0;
  logic lat_we = 0;
  logic [1:0] lat_sel = 0;
  logic [LW-1:0] lat_plane = 0, lat_row = 0, rd_plane = 0, rd_row = 0;
  logic [L-1:0] lat_data = 0, rd_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hb_lattice_engine #(.L(L), .ENG(ENG)) u_hb_lattice_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
    .seed_we(seed_we), .seed_eng(seed_eng), .seed_data(seed_data),
    .lat_we(lat_we), .lat_sel(lat_sel), .lat_plane(lat_plane), .lat_row(lat_row),
    .lat_data(lat_data), .rd_plane(rd_plane), .rd_row(rd_row), .rd_data(rd_data)
  );

  logic [L-1:0] ms [L][L];
  logic [L-1:0] mj [3][L][L];
  logic [31:0]  mthr [7];
  logic [31:0]  mh [ENG][61];
  logic [31:0]  lcg = 32'h1234_5678;

  function automatic logic [31:0] nextr();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg ^ (lcg >> 13);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] draw(input int e);
    logic [31:0] r;
    r = (mh[e][23] + mh[e][54]) ^ mh[e][60];
    for (int i = 60; i > 0; i--) mh[e][i] = mh[e][i-1];
    mh[e][0] = r;
    return r;
  endfunction

  task automatic model_sweep();
    for (int z = 0; z < L; z++)
      for (int c = 0; c < 2; c++)
        for (int k = 0; k < CPC; k++)
          for (int e = 0; e < ENG; e++) begin
            int g, y, x, n;
            logic [31:0] r;
            g = k * ENG + e;
            y = g / (L / 2);
            x = 2 * (g % (L / 2)) + ((y + z + c) % 2);
            n = 0;
            n += int'(mj[0][z][y][x]           == ms[z][y][(x+1)%L]);
            n += int'(mj[0][z][y][(x+L-1)%L]   == ms[z][y][(x+L-1)%L]);
            n += int'(mj[1][z][y][x]           == ms[z][(y+1)%L][x]);
            n += int'(mj[1][z][(y+L-1)%L][x]   == ms[z][(y+L-1)%L][x]);
            n += int'(mj[2][z][y][x]           == ms[(z+1)%L][y][x]);
            n += int'(mj[2][(z+L-1)%L][y][x]   == ms[(z+L-1)%L][y][x]);
            r = draw(e);
            ms[z][y][x] = (r < mthr[n]);
          end
  endtask

  task automatic lat_write(input logic [1:0] sel, input int z, input int y, input logic [L-1:0] d);
    @(negedge clk);
    lat_we = 1; lat_sel = sel; lat_plane = LW'(z); lat_row = LW'(y); lat_data = d;
    @(posedge clk);
    @(negedge clk);
    lat_we = 0;
  endtask

  task automatic tbl_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    tbl_we = 1; tbl_idx = 3'(idx); tbl_data = d;
    @(posedge clk);
    @(negedge clk);
    tbl_we = 0;
    mthr[idx] = d;
  endtask

  task automatic load_logistic(input real beta);
    for (int n = 0; n < 7; n++) begin
      real p, v;
      logic [31:0] t;
      p = 1.0 / (1.0 + $exp(-2.0 * beta * real'(2 * n - 6)));
      v = p * 4294967296.0;
      if (n == 3) t = 32'h8000_0000;
      else if (v >= 4294967295.0) t = 32'hFFFF_FFFF;
      else t = 32'(longint'(v));
      tbl_write(n, t);
    end
  endtask

  task automatic run_sweep(input bit disturb, input string tag);
    @(negedge clk);
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    check(busy && !done, "R2 busy after start", {62'd0, busy, done}, 64'd2);
    for (int i = 1; i <= TOTAL; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (disturb && i == 3) begin
        start = 1; lat_we = 1; lat_sel = 0; lat_plane = 0; lat_row = 0; lat_data = '1;
        tbl_we = 1; tbl_idx = 3; tbl_data = 32'h0;
        seed_we = 1; seed_eng = 0; seed_data = 32'hDEAD_BEEF;
      end else begin
        start = 0; lat_we = 0; tbl_we = 0; seed_we = 0;
      end
      if (i == TOTAL - 1)
        check(!done && busy, {"R3 done early ", tag}, {62'd0, busy, done}, 64'd2);
      if (i == TOTAL)
        check(done && !busy, {"R3 done due ", tag}, {62'd0, busy, done}, 64'd1);
    end
  endtask

  task automatic compare_lattice(input string tag);
    for (int z = 0; z < L; z++)
      for (int y = 0; y < L; y++) begin
        rd_plane = LW'(z); rd_row = LW'(y);
        #1;
        check(rd_data === ms[z][y], tag, 64'(rd_data), 64'(ms[z][y]));
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int e = 0; e < ENG; e++) for (int i = 0; i < 61; i++) mh[e][i] = 0;
    for (int i = 0; i < 7; i++) mthr[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    check(!busy && !done, "R1 reset flags", {62'd0, busy, done}, 64'd0);
    for (int z = 0; z < L; z++) for (int y = 0; y < L; y++) ms[z][y] = '0;
    compare_lattice("R1 reset spins");

    for (int s = 0; s < 4; s++)
      for (int z = 0; z < L; z++)
        for (int y = 0; y < L; y++) begin
          logic [L-1:0] d;
          d = L'(nextr());
          if (s == 0) ms[z][y] = d; else mj[s-1][z][y] = d;
          lat_write(2'(s), z, y, d);
        end
    compare_lattice("R8 lattice write");

    for (int e = 0; e < ENG; e++)
      for (int i = 0; i < 61; i++) begin
        logic [31:0] w;
        w = nextr();
        @(negedge clk);
        seed_we = 1; seed_eng = EW'(e); seed_data = w;
        @(posedge clk);
        @(negedge clk);
        seed_we = 0;
        for (int j = 60; j > 0; j--) mh[e][j] = mh[e][j-1];
        mh[e][0] = w;
      end

    load_logistic(0.3);
    run_sweep(0, "sweep1");
    model_sweep();
    compare_lattice("R4 R5 R6 heat-bath sweep1");

    run_sweep(1, "sweep2");
    model_sweep();
    compare_lattice("R2 R5 R8 sweep with busy-time writes ignored");

    load_logistic(0.8);
    run_sweep(0, "sweep3");
    model_sweep();
    compare_lattice("R4 R6 sweep at lower temperature");

    for (int n = 0; n < 7; n++) tbl_write(n, 32'h0);
    run_sweep(0, "zero table");
    model_sweep();
    for (int z = 0; z < L; z++)
      for (int y = 0; y < L; y++) begin
        rd_plane = LW'(z); rd_row = LW'(y);
        #1;
        check(rd_data === '0, "R7 zero thresholds give all down", 64'(rd_data), 64'd0);
      end

    for (int n = 0; n < 7; n++) tbl_write(n, 32'hFFFF_FFFF);
    run_sweep(0, "ones table");
    model_sweep();
    compare_lattice("R7 all-ones thresholds");
    rd_plane = LW'(L - 1); rd_row = LW'(L - 1);
    #1;
    check(rd_data === {L{1'b1}}, "R7 all up row", 64'(rd_data), 64'({L{1'b1}}));

    load_logistic(0.5);
    run_sweep(0, "sweep4");
    model_sweep();
    compare_lattice("R4 R9 readback after old values all up");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule